// File: doc/BRIEF.md
# Byte-Lane Bridge for a 16-bit ATA Data Port

This block sits between an 8-bit CPU I/O bus and a 16-bit ATA/IDE device. It occupies a 32-byte I/O window. The active-low window select and the five low address bits are decoded, purely combinationally, into four selects: a real-time clock, the device's primary register bank, the device's secondary register bank, and two upper-byte latch ports. All command and status traffic to the device is 8 bits wide and uses the low byte lane. Only the device data register at offset 0x18 carries 16 bits.

Two one-direction byte latches let 8-bit CPU cycles carry the 16-bit data word. When the CPU reads offset 0x18, it receives the device's low byte. In that same cycle the device's high byte is caught in the read latch, and a later CPU read of offset 0x14 returns it. For a write, software first stores the high byte at offset 0x15. The next CPU write to 0x18 then places the CPU byte on the low lane, and the latched byte goes onto the high lane in the same cycle. The strobes are assumed to be aligned to the clock already, so no wait states are inserted.

Top module: `ata_byte_bridge`

## Requirements
- R1: With `io_sel_n` low, the window offset selects one region. Offsets 0x00–0x13 assert `rtc_cs`. Offsets 0x16–0x17 assert `dev_cs_sec`, with `dev_addr` equal to offset minus 0x16. Offsets 0x18–0x1F assert `dev_cs_pri`, with `dev_addr` equal to offset minus 0x18. Offsets 0x14–0x15 assert none of these three selects.
- R2: With `io_sel_n` high, every select, `dev_rd`, `dev_wr`, both output enables and `cpu_rdata` are low, whatever the address and strobes.
- R3: A CPU read of offset 0x18 asserts `dev_rd` and returns `dev_din[7:0]` on `cpu_rdata` in the same cycle.
- R4: A CPU read of 0x18 captures `dev_din[15:8]` into the read latch at the clock edge. A CPU read of 0x14 returns the latch value and does not assert `dev_rd`.
- R5: A CPU write to offset 0x15 stores `cpu_wdata` into the write latch and does not assert `dev_wr` or any device select.
- R6: A CPU write to 0x18 asserts `dev_wr`, `dev_lo_oe` and `dev_hi_oe`, with `dev_dout` equal to {write latch, `cpu_wdata`}. `dev_hi_oe` is never asserted in any other cycle.
- R7: A CPU access to any device register other than 0x18 (offsets 0x16, 0x17 and 0x19–0x1F) uses only the low lane. A write asserts `dev_wr` and `dev_lo_oe` with `dev_hi_oe` low. A read returns `dev_din[7:0]`.
- R8: Synchronous reset clears both latches to 0x00.
- R9: Reading offset 0x15 returns 0x00. Writing offset 0x14 changes neither latch.
- R10: A read of offsets 0x00–0x13 returns `rtc_rdata`. `cpu_rdata` is 0x00 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel_n | input | 1 | Active-low select of the 32-byte window |
| cpu_addr | input | 5 | Offset within the window |
| cpu_rd | input | 1 | CPU read strobe, clock aligned |
| cpu_wr | input | 1 | CPU write strobe, clock aligned |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte |
| rtc_cs | output | 1 | Real-time clock select |
| rtc_rdata | input | 8 | Read data from the real-time clock |
| dev_cs_pri | output | 1 | Device primary register bank select |
| dev_cs_sec | output | 1 | Device secondary register bank select |
| dev_addr | output | 3 | Register index within the selected bank |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_din | input | 16 | Data driven by the device |
| dev_dout | output | 16 | Data toward the device |
| dev_lo_oe | output | 1 | Output enable for the low lane of `dev_dout` |
| dev_hi_oe | output | 1 | Output enable for the high lane of `dev_dout` |

## Verification
The bench builds the block with its default parameters: an 8-bit lane, a 5-bit offset and the stated region boundaries. With these settings the whole window of 32 offsets can be swept for reads and writes, both with the window selected and with it deselected. Every select, strobe, enable and read byte is compared against values worked out from the offset alone. A device model in the bench holds a 16-bit data queue, so the byte order of split transfers can be checked. Write-latch-then-data sequences and data-then-read-latch sequences use several byte patterns, and each pattern is tied to the exact word that reaches or leaves the queue.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;
  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_RTC  = 3'd1,
    RGN_RLAT = 3'd2,
    RGN_WLAT = 3'd3,
    RGN_SEC  = 3'd4,
    RGN_PRI  = 3'd5
  } region_e;
endpackage

// File: rtl/ab_decode.sv
module ab_decode
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DEV_AW   = 3,
  parameter int RTC_LAST = 'h13,
  parameter int RLAT_OFS = 'h14,
  parameter int WLAT_OFS = 'h15,
  parameter int SEC_BASE = 'h16,
  parameter int PRI_BASE = 'h18,
  parameter int DATA_OFS = 'h18
) (
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              is_data,
  output logic [DEV_AW-1:0] dev_addr
);
  int unsigned a_i;
  assign a_i = 32'(addr);

  always_comb begin
    region   = RGN_NONE;
    dev_addr = '0;
    if (!sel_n) begin
      if (a_i <= RTC_LAST)            region = RGN_RTC;
      else if (a_i == RLAT_OFS)       region = RGN_RLAT;
      else if (a_i == WLAT_OFS)       region = RGN_WLAT;
      else if (a_i < PRI_BASE) begin
        region   = RGN_SEC;
        dev_addr = DEV_AW'(a_i - SEC_BASE);
      end else begin
        region   = RGN_PRI;
        dev_addr = DEV_AW'(a_i - PRI_BASE);
      end
    end
  end

  assign is_data = (!sel_n) && (a_i == DATA_OFS);
endmodule

// File: rtl/ab_byte_latch.sv
module ab_byte_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R5
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));
endmodule

// File: rtl/ab_rdmux.sv
module ab_rdmux
  import ata_bridge_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  region_e      region,
  input  logic [W-1:0] rtc_data,
  input  logic [W-1:0] dev_lo,
  input  logic [W-1:0] rlat_q,
  output logic [W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (region)
        RGN_RTC:          rdata = rtc_data;
        RGN_RLAT:         rdata = rlat_q;
        RGN_SEC, RGN_PRI: rdata = dev_lo;
        default:          rdata = '0;
      endcase
    end
  end

  // R9
  wlat_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && region == RGN_WLAT) |-> (rdata == '0));

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |-> (rdata == '0));
endmodule

// File: rtl/ata_byte_bridge.sv
module ata_byte_bridge
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int DEV_AW   = 3,
  parameter int RTC_LAST = 'h13,
  parameter int RLAT_OFS = 'h14,
  parameter int WLAT_OFS = 'h15,
  parameter int SEC_BASE = 'h16,
  parameter int PRI_BASE = 'h18,
  parameter int DATA_OFS = 'h18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                io_sel_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                rtc_cs,
  input  logic [DATA_W-1:0]   rtc_rdata,
  output logic                dev_cs_pri,
  output logic                dev_cs_sec,
  output logic [DEV_AW-1:0]   dev_addr,
  output logic                dev_rd,
  output logic                dev_wr,
  input  logic [2*DATA_W-1:0] dev_din,
  output logic [2*DATA_W-1:0] dev_dout,
  output logic                dev_lo_oe,
  output logic                dev_hi_oe
);
  localparam int DW2 = 2 * DATA_W;

  region_e           region;
  logic              is_data;
  logic              dev_any;
  logic              rl_load, wl_load;
  logic [DATA_W-1:0] rl_q, wl_q;

  ab_decode #(
    .ADDR_W(ADDR_W), .DEV_AW(DEV_AW), .RTC_LAST(RTC_LAST),
    .RLAT_OFS(RLAT_OFS), .WLAT_OFS(WLAT_OFS), .SEC_BASE(SEC_BASE),
    .PRI_BASE(PRI_BASE), .DATA_OFS(DATA_OFS)
  ) u_dec (
    .sel_n(io_sel_n), .addr(cpu_addr), .region(region),
    .is_data(is_data), .dev_addr(dev_addr)
  );

  assign rtc_cs     = (region == RGN_RTC);
  assign dev_cs_pri = (region == RGN_PRI);
  assign dev_cs_sec = (region == RGN_SEC);
  assign dev_any    = dev_cs_pri | dev_cs_sec;
  assign dev_rd     = cpu_rd & dev_any;
  assign dev_wr     = cpu_wr & dev_any;
  assign dev_lo_oe  = cpu_wr & dev_any;
  assign dev_hi_oe  = cpu_wr & is_data;

  assign rl_load = cpu_rd & is_data;
  assign wl_load = cpu_wr & (region == RGN_WLAT);

  ab_byte_latch #(.W(DATA_W)) u_rlat (
    .clk(clk), .rst(rst), .load(rl_load),
    .d(dev_din[DW2-1:DATA_W]), .q(rl_q)
  );

  ab_byte_latch #(.W(DATA_W)) u_wlat (
    .clk(clk), .rst(rst), .load(wl_load), .d(cpu_wdata), .q(wl_q)
  );

  assign dev_dout = {wl_q, cpu_wdata};

  ab_rdmux #(.W(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .rd(cpu_rd), .region(region),
    .rtc_data(rtc_rdata), .dev_lo(dev_din[DATA_W-1:0]),
    .rlat_q(rl_q), .rdata(cpu_rdata)
  );

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    io_sel_n |-> !(dev_rd || dev_wr || rtc_cs || dev_cs_pri || dev_cs_sec || dev_hi_oe));

  // R6
  hi_oe_data_only_chk: assert property (@(posedge clk) disable iff (rst)
    dev_hi_oe |-> (dev_wr && dev_cs_pri && dev_addr == '0));

  // R4
  rlat_read_no_dev_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && region == RGN_RLAT) |-> !dev_rd);

  // R5
  wlat_write_no_dev_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && region == RGN_WLAT) |-> !(dev_wr || dev_cs_pri || dev_cs_sec));
endmodule

// File: tb/ata_byte_bridge_tb_top.sv
module ata_byte_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        io_sel_n;
  logic [4:0]  cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        rtc_cs;
  logic [7:0]  rtc_rdata;
  logic        dev_cs_pri, dev_cs_sec;
  logic [2:0]  dev_addr;
  logic        dev_rd, dev_wr;
  logic [15:0] dev_din, dev_dout;
  logic        dev_lo_oe, dev_hi_oe;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ata_byte_bridge dut_i (
    .clk(clk), .rst(rst), .io_sel_n(io_sel_n), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rtc_cs(rtc_cs), .rtc_rdata(rtc_rdata),
    .dev_cs_pri(dev_cs_pri), .dev_cs_sec(dev_cs_sec), .dev_addr(dev_addr),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_din(dev_din), .dev_dout(dev_dout),
    .dev_lo_oe(dev_lo_oe), .dev_hi_oe(dev_hi_oe)
  );

  // Device model: register file plus a 16-bit data queue at primary index 0
  logic [15:0] q_mem [16];
  logic [3:0]  q_wp = '0, q_rp = '0;
  initial for (int i = 0; i < 16; i++) q_mem[i] = 16'h0000;

  always_comb begin
    if (dev_cs_pri && dev_addr == 3'd0) dev_din = q_mem[q_rp];
    else if (dev_cs_pri)                dev_din = {8'hEE, 8'h80 | {5'b0, dev_addr}};
    else if (dev_cs_sec)                dev_din = {8'hDD, 8'h40 | {5'b0, dev_addr}};
    else                                dev_din = 16'hBEEF;
  end

  always @(posedge clk) begin
    if (dev_wr && dev_cs_pri && dev_addr == 3'd0) begin
      q_mem[q_wp] <= {dev_hi_oe ? dev_dout[15:8] : 8'hXX, dev_lo_oe ? dev_dout[7:0] : 8'hXX};
      q_wp <= q_wp + 4'd1;
    end
    if (dev_rd && dev_cs_pri && dev_addr == 3'd0) q_rp <= q_rp + 4'd1;
  end

  assign rtc_rdata = 8'h3C ^ {3'b0, cpu_addr};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at negedge, sample mid low phase, edge, release at next negedge
  task automatic start_cycle(input bit sel, input logic [4:0] a, input bit rd, input bit wr, input logic [7:0] wd);
    @(negedge clk);
    io_sel_n = ~sel; cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    #5;
  endtask

  task automatic end_cycle();
    @(negedge clk);
    io_sel_n = 1'b1; cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [4:0] a, output logic [7:0] d);
    start_cycle(1, a, 1, 0, 8'h00);
    d = cpu_rdata;
    end_cycle();
  endtask

  task automatic cpu_write(input logic [4:0] a, input logic [7:0] d);
    start_cycle(1, a, 0, 1, d);
    end_cycle();
  endtask

  logic [7:0] exp_rl = 8'h00, exp_wl = 8'h00;

  initial begin
    #(20 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd_v;
    io_sel_n = 1'b1; cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: both latches clear after reset
    cpu_read(5'h14, rd_v);
    chk(rd_v == 8'h00, "R8 read latch reset", rd_v, 0);
    start_cycle(1, 5'h18, 0, 1, 8'h11);
    chk(dev_dout[15:8] == 8'h00, "R8 write latch reset", dev_dout[15:8], 0);
    end_cycle();

    // R2: deselected sweep
    for (int a = 0; a < 32; a++) begin
      for (int m = 0; m < 2; m++) begin
        start_cycle(0, 5'(a), m == 0, m == 1, 8'hA5);
        chk(!(rtc_cs | dev_cs_pri | dev_cs_sec | dev_rd | dev_wr | dev_lo_oe | dev_hi_oe),
            "R2 deselected outputs", {rtc_cs, dev_cs_pri, dev_cs_sec, dev_rd, dev_wr, dev_lo_oe, dev_hi_oe}, 0);
        chk(cpu_rdata == 8'h00, "R2 deselected rdata", cpu_rdata, 0);
        end_cycle();
      end
    end

    // R1 R3 R4 R7 R9 R10: selected read sweep
    for (int a = 0; a < 32; a++) begin
      logic [7:0] exp_d;
      logic [15:0] head;
      head = q_mem[q_rp];
      start_cycle(1, 5'(a), 1, 0, 8'h00);
      chk(rtc_cs == (a <= 'h13), "R1 rtc select", rtc_cs, (a <= 'h13));
      chk(dev_cs_sec == (a == 'h16 || a == 'h17), "R1 secondary select", dev_cs_sec, 0);
      chk(dev_cs_pri == (a >= 'h18), "R1 primary select", dev_cs_pri, (a >= 'h18));
      if (a >= 'h18) chk(dev_addr == 3'(a - 'h18), "R1 primary index", dev_addr, a - 'h18);
      if (a == 'h16 || a == 'h17) chk(dev_addr == 3'(a - 'h16), "R1 secondary index", dev_addr, a - 'h16);
      chk(dev_rd == (a >= 'h16), "R4 R7 device read strobe", dev_rd, (a >= 'h16));
      chk(dev_hi_oe == 1'b0 && dev_lo_oe == 1'b0, "R6 no enable on read", dev_hi_oe, 0);
      if (a <= 'h13)       exp_d = 8'h3C ^ 8'(a);
      else if (a == 'h14)  exp_d = exp_rl;
      else if (a == 'h15)  exp_d = 8'h00;
      else if (a == 'h18)  exp_d = head[7:0];
      else if (a >= 'h19)  exp_d = 8'h80 | 8'(a - 'h18);
      else                 exp_d = 8'h40 | 8'(a - 'h16);
      chk(cpu_rdata == exp_d, "R3 R9 R10 read data", cpu_rdata, exp_d);
      end_cycle();
      if (a == 'h18) exp_rl = head[15:8];
    end

    // R5 R6 R7 R9: selected write sweep
    for (int a = 0; a < 32; a++) begin
      logic [7:0] wd;
      wd = 8'(a) ^ 8'h5A;
      start_cycle(1, 5'(a), 0, 1, wd);
      chk(dev_wr == (a >= 'h16), "R5 R7 device write strobe", dev_wr, (a >= 'h16));
      chk(dev_lo_oe == (a >= 'h16), "R7 low enable", dev_lo_oe, (a >= 'h16));
      chk(dev_hi_oe == (a == 'h18), "R6 high enable only at data", dev_hi_oe, (a == 'h18));
      if (a >= 'h16) chk(dev_dout == {exp_wl, wd}, "R6 R7 device data", dev_dout, {exp_wl, wd});
      end_cycle();
      if (a == 'h15) exp_wl = wd;
    end
    cpu_read(5'h14, rd_v);
    chk(rd_v == exp_rl, "R9 write to 0x14 ignored", rd_v, exp_rl);

    // R5 R6: write latch then data, several patterns
    for (int p = 0; p < 8; p++) begin
      logic [7:0] hi, lo;
      logic [3:0] slot;
      hi = 8'(p * 37 + 3); lo = 8'(p * 91 + 200);
      cpu_write(5'h15, hi);
      slot = q_wp;
      cpu_write(5'h18, lo);
      chk(q_mem[slot] == {hi, lo}, "R5 R6 split write word", q_mem[slot], {hi, lo});
    end

    // R3 R4: data then read latch, several patterns
    for (int p = 0; p < 8; p++) begin
      logic [15:0] w;
      logic [7:0] lo_r, hi_r;
      w = q_mem[q_rp];
      cpu_read(5'h18, lo_r);
      cpu_read(5'h14, hi_r);
      chk(lo_r == w[7:0], "R3 split read low", lo_r, w[7:0]);
      chk(hi_r == w[15:8], "R4 split read high", hi_r, w[15:8]);
      cpu_read(5'h14, hi_r);
      chk(hi_r == w[15:8], "R4 latch holds", hi_r, w[15:8]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule